// File: doc/BRIEF.md
# USB Subsystem Power-Up Reset Sequencer

This block is a hardware state machine that brings a dual-speed USB controller subsystem out of reset in a fixed order, with no software stepping through the sequence. A one-cycle start request latches the configuration inputs and asserts the PHY, host-controller and control-logic resets together. The divider for the controller clock is then held in reset, configured and released. After that the reference clock, spread-spectrum and both PHY power domains are switched on. Next the control-logic reset is released, and then the host-controller reset, each with a settling wait. The interface clock is turned on, host mode is selected and, as the very last action, the PHY reset is released.

Each settling wait counts pulses of a controller-clock enable input (`ctl_tick_i`), not cycles of `clk`. A wait therefore lasts as long as the slower clock needs, whatever the ratio between the two clocks. Every control output comes straight from a flop, and the outputs only ever switch in the order given below. `busy_o` is high while the sequence runs. `done_o` stays high from the end of the sequence until the next start that is accepted. There is no data stream here, so all pins are plain control levels and nothing uses a handshake.

Top module: `usb_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is idle. `phy_rst_o`, `hc_rst_o` and `ctl_rst_o` are 1. Every enable, power, configuration output, `div_rst_o`, `busy_o` and `done_o` are 0.
- R2: In the cycle after `start_i` is accepted, all three domain resets are 1, `busy_o` is 1 and `done_o` is 0. Outputs from an earlier run are cleared. A start is accepted only when the block is idle or done.
- R3: `div_rst_o` rises before `hclk_en_o`. `hclk_en_o` rises together with `div_sel_o` taking the latched divider code, while `div_rst_o` is still 1. `div_rst_o` falls only after that.
- R4: `ref_sel_o`, `mult_o`, `ssc_en_o`, `ss_ref_en_o`, `hs_pwr_o` and `ss_pwr_o` all take their active values while all three domain resets are still 1.
- R5: `ctl_rst_o` falls after at least `WAIT_TICKS` controller ticks have passed since power came on. Port power control is applied only after a further `WAIT_TICKS` ticks.
- R6: `ppc_en_o` is 1, and `ppc_high_o` equals the latched polarity, before `hc_rst_o` falls. `if_clk_en_o` rises only after at least `WAIT_TICKS` ticks have passed since `hc_rst_o` fell.
- R7: `phy_rst_o` falls last, in the same cycle that `done_o` rises and `busy_o` falls.
- R8: `if_clk_en_o` rises one cycle before `host_mode_o`. `host_mode_o = 1` means host mode, which is role bit 0.
- R9: A start request while `busy_o` is 1 is ignored. Changes on the configuration inputs during a run have no effect, because the values are latched at the accepted start.
- R10: `done_o` stays 1, and all outputs hold, until the next start request.
- R11: If `rst_n` goes low at any point in the sequence, the block returns at once to the idle state of R1.
- R12: A settling wait advances only on `ctl_tick_i` pulses. With no ticks the sequence stays in its wait with `busy_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| start_i | input | 1 | Start request, sampled on each clock edge |
| ctl_tick_i | input | 1 | One pulse per controller-clock period |
| div_sel_i | input | DIV_W | Controller clock divider code |
| ref_sel_i | input | REF_W | Reference clock source select |
| mult_i | input | MULT_W | PLL reference multiplier |
| ppc_high_i | input | 1 | Port power polarity, 1 = active high |
| phy_rst_o | output | 1 | PHY reset |
| hc_rst_o | output | 1 | Host-controller reset |
| ctl_rst_o | output | 1 | Control-logic reset |
| div_rst_o | output | 1 | Controller clock divider reset |
| div_sel_o | output | DIV_W | Applied divider code |
| hclk_en_o | output | 1 | Controller clock enable |
| ref_sel_o | output | REF_W | Applied reference clock select |
| mult_o | output | MULT_W | Applied multiplier |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ss_ref_en_o | output | 1 | SuperSpeed reference prescaler enable |
| hs_pwr_o | output | 1 | HighSpeed PHY power |
| ss_pwr_o | output | 1 | SuperSpeed PHY power |
| ppc_en_o | output | 1 | Port power control enable |
| ppc_high_o | output | 1 | Applied port power polarity |
| if_clk_en_o | output | 1 | Interface clock enable |
| host_mode_o | output | 1 | Host role selected |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete |

## Verification
The bench builds the block with `WAIT_TICKS = 3` and the default field widths. This keeps each run short, so every wait can be swept against tick periods of 1, 2 and 3 clocks, and the tick counts between releases can be checked against exact bounds. Because the waits are short, a start request and a configuration change can be made to land inside a wait. Runs are also made with ticks held off, which shows the wait stalling, and with an asynchronous reset applied partway through a run.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  // Ordinals matter: the output decode compares against them.
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_ASRT    = 4'd1,
    ST_DIV_RST = 4'd2,
    ST_DIV_CFG = 4'd3,
    ST_DIV_REL = 4'd4,
    ST_PWR_ON  = 4'd5,
    ST_WAIT_A  = 4'd6,
    ST_REL_CTL = 4'd7,
    ST_WAIT_B  = 4'd8,
    ST_PPC     = 4'd9,
    ST_REL_HC  = 4'd10,
    ST_WAIT_C  = 4'd11,
    ST_IFCLK   = 4'd12,
    ST_HOST    = 4'd13,
    ST_DONE    = 4'd14
  } seq_st_e;

  function automatic logic is_wait(seq_st_e s);
    return (s == ST_WAIT_A) || (s == ST_WAIT_B) || (s == ST_WAIT_C);
  endfunction

endpackage

// File: rtl/pwrseq_cfg_latch.sv
module pwrseq_cfg_latch #(
  parameter int DIV_W  = 3,
  parameter int REF_W  = 2,
  parameter int MULT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic [REF_W-1:0]  ref_sel_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              ppc_high_i,
  output logic [DIV_W-1:0]  div_sel_q,
  output logic [REF_W-1:0]  ref_sel_q,
  output logic [MULT_W-1:0] mult_q,
  output logic              ppc_high_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel_q  <= '0;
      ref_sel_q  <= '0;
      mult_q     <= '0;
      ppc_high_q <= 1'b0;
    end else if (take_i) begin
      div_sel_q  <= div_sel_i;
      ref_sel_q  <= ref_sel_i;
      mult_q     <= mult_i;
      ppc_high_q <= ppc_high_i;
    end
  end

endmodule

// File: rtl/pwrseq_wait.sv
module pwrseq_wait #(
  parameter int WAIT_TICKS = 10,
  localparam int CNT_W = (WAIT_TICKS < 2) ? 1 : $clog2(WAIT_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = arm_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!arm_i || expire_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    expire_i,
  output logic    take_o,
  output logic    arm_o,
  output seq_st_e st_q,
  output seq_st_e st_d
);

  logic idle_like;

  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign take_o    = idle_like && start_i;
  assign arm_o     = is_wait(st_q);

  always_comb begin
    st_d = st_q;
    if (idle_like) begin
      if (start_i) st_d = ST_ASRT;
    end else if (arm_o) begin
      if (expire_i) st_d = seq_st_e'(st_q + 4'd1);
    end else begin
      st_d = seq_st_e'(st_q + 4'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/pwrseq_drive.sv
module pwrseq_drive
  import pwrseq_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int REF_W  = 2,
  parameter int MULT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_e           st_d,
  input  logic [DIV_W-1:0]  div_sel_q,
  input  logic [REF_W-1:0]  ref_sel_q,
  input  logic [MULT_W-1:0] mult_q,
  input  logic              ppc_high_q,
  output logic              phy_rst_o,
  output logic              hc_rst_o,
  output logic              ctl_rst_o,
  output logic              div_rst_o,
  output logic [DIV_W-1:0]  div_sel_o,
  output logic              hclk_en_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              ssc_en_o,
  output logic              ss_ref_en_o,
  output logic              hs_pwr_o,
  output logic              ss_pwr_o,
  output logic              ppc_en_o,
  output logic              ppc_high_o,
  output logic              if_clk_en_o,
  output logic              host_mode_o,
  output logic              busy_o,
  output logic              done_o
);

  logic [3:0] ord;
  logic       clk_on, pwr_on, ppc_on;

  assign ord    = st_d;
  assign clk_on = (ord >= ST_DIV_CFG) && (ord != ST_IDLE);
  assign pwr_on = ord >= ST_PWR_ON;
  assign ppc_on = ord >= ST_PPC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_rst_o   <= 1'b1;
      hc_rst_o    <= 1'b1;
      ctl_rst_o   <= 1'b1;
      div_rst_o   <= 1'b0;
      div_sel_o   <= '0;
      hclk_en_o   <= 1'b0;
      ref_sel_o   <= '0;
      mult_o      <= '0;
      ssc_en_o    <= 1'b0;
      ss_ref_en_o <= 1'b0;
      hs_pwr_o    <= 1'b0;
      ss_pwr_o    <= 1'b0;
      ppc_en_o    <= 1'b0;
      ppc_high_o  <= 1'b0;
      if_clk_en_o <= 1'b0;
      host_mode_o <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      phy_rst_o   <= ord != ST_DONE;
      hc_rst_o    <= ord < ST_REL_HC;
      ctl_rst_o   <= ord < ST_REL_CTL;
      div_rst_o   <= (ord == ST_DIV_RST) || (ord == ST_DIV_CFG);
      div_sel_o   <= clk_on ? div_sel_q : '0;
      hclk_en_o   <= clk_on;
      ref_sel_o   <= pwr_on ? ref_sel_q : '0;
      mult_o      <= pwr_on ? mult_q : '0;
      ssc_en_o    <= pwr_on;
      ss_ref_en_o <= pwr_on;
      hs_pwr_o    <= pwr_on;
      ss_pwr_o    <= pwr_on;
      ppc_en_o    <= ppc_on;
      ppc_high_o  <= ppc_on && ppc_high_q;
      if_clk_en_o <= ord >= ST_IFCLK;
      host_mode_o <= ord >= ST_HOST;
      busy_o      <= (ord != ST_IDLE) && (ord != ST_DONE);
      done_o      <= ord == ST_DONE;
    end
  end

endmodule

// File: rtl/usb_pwrup_seq.sv
module usb_pwrup_seq
  import pwrseq_pkg::*;
#(
  parameter int DIV_W      = 3,
  parameter int REF_W      = 2,
  parameter int MULT_W     = 7,
  parameter int WAIT_TICKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ctl_tick_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic [REF_W-1:0]  ref_sel_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              ppc_high_i,
  output logic              phy_rst_o,
  output logic              hc_rst_o,
  output logic              ctl_rst_o,
  output logic              div_rst_o,
  output logic [DIV_W-1:0]  div_sel_o,
  output logic              hclk_en_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              ssc_en_o,
  output logic              ss_ref_en_o,
  output logic              hs_pwr_o,
  output logic              ss_pwr_o,
  output logic              ppc_en_o,
  output logic              ppc_high_o,
  output logic              if_clk_en_o,
  output logic              host_mode_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_st_e           st_q, st_d;
  logic              take, arm, expire;
  logic [DIV_W-1:0]  div_sel_q;
  logic [REF_W-1:0]  ref_sel_q;
  logic [MULT_W-1:0] mult_q;
  logic              ppc_high_q;

  pwrseq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .expire_i (expire),
    .take_o   (take),
    .arm_o    (arm),
    .st_q     (st_q),
    .st_d     (st_d)
  );

  pwrseq_wait #(.WAIT_TICKS(WAIT_TICKS)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm),
    .tick_i   (ctl_tick_i),
    .expire_o (expire)
  );

  pwrseq_cfg_latch #(.DIV_W(DIV_W), .REF_W(REF_W), .MULT_W(MULT_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .div_sel_i  (div_sel_i),
    .ref_sel_i  (ref_sel_i),
    .mult_i     (mult_i),
    .ppc_high_i (ppc_high_i),
    .div_sel_q  (div_sel_q),
    .ref_sel_q  (ref_sel_q),
    .mult_q     (mult_q),
    .ppc_high_q (ppc_high_q)
  );

  pwrseq_drive #(.DIV_W(DIV_W), .REF_W(REF_W), .MULT_W(MULT_W)) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_d        (st_d),
    .div_sel_q   (div_sel_q),
    .ref_sel_q   (ref_sel_q),
    .mult_q      (mult_q),
    .ppc_high_q  (ppc_high_q),
    .phy_rst_o   (phy_rst_o),
    .hc_rst_o    (hc_rst_o),
    .ctl_rst_o   (ctl_rst_o),
    .div_rst_o   (div_rst_o),
    .div_sel_o   (div_sel_o),
    .hclk_en_o   (hclk_en_o),
    .ref_sel_o   (ref_sel_o),
    .mult_o      (mult_o),
    .ssc_en_o    (ssc_en_o),
    .ss_ref_en_o (ss_ref_en_o),
    .hs_pwr_o    (hs_pwr_o),
    .ss_pwr_o    (ss_pwr_o),
    .ppc_en_o    (ppc_en_o),
    .ppc_high_o  (ppc_high_o),
    .if_clk_en_o (if_clk_en_o),
    .host_mode_o (host_mode_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic phy_rst_o,
  input logic hc_rst_o,
  input logic ctl_rst_o,
  input logic div_rst_o,
  input logic hclk_en_o,
  input logic ssc_en_o,
  input logic ss_ref_en_o,
  input logic hs_pwr_o,
  input logic ss_pwr_o,
  input logic ppc_en_o,
  input logic if_clk_en_o,
  input logic host_mode_o,
  input logic busy_o,
  input logic done_o
);

  // R1: idle state held while reset is low
  p_idle_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (phy_rst_o && hc_rst_o && ctl_rst_o && !hclk_en_o && !busy_o && !done_o));

  // R3: divider reset falls only with the controller clock already enabled
  p_div_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_rst_o) |-> hclk_en_o);

  // R4: power domains are on whenever the control-logic reset is released
  p_pwr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rst_o |-> (hs_pwr_o && ss_pwr_o && ssc_en_o && ss_ref_en_o));

  // R5: host-controller reset never releases ahead of control logic
  p_ctl_before_hc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hc_rst_o |-> !ctl_rst_o);

  // R6: port power control already applied when the host controller leaves reset
  p_ppc_before_hc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hc_rst_o |-> ppc_en_o);

  // R7: PHY reset is the last release
  p_phy_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst_o |-> (!hc_rst_o && host_mode_o && done_o));

  // R8: host mode implies interface clock running
  p_host_after_if_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode_o |-> if_clk_en_o);

  // R10: done holds until a start request
  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R2: busy and done are never both set
  p_busy_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

endmodule

bind usb_pwrup_seq pwrseq_chk u_chk (.*);

// File: tb/tb_usb_pwrup_seq.sv
module tb_usb_pwrup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic start_i = 1'b0;
  logic ctl_tick_i = 1'b0;
  logic [2:0] div_sel_i = '0;
  logic [1:0] ref_sel_i = '0;
  logic [6:0] mult_i = '0;
  logic ppc_high_i = 1'b0;
  logic phy_rst_o, hc_rst_o, ctl_rst_o, div_rst_o, hclk_en_o;
  logic [2:0] div_sel_o;
  logic [1:0] ref_sel_o;
  logic [6:0] mult_o;
  logic ssc_en_o, ss_ref_en_o, hs_pwr_o, ss_pwr_o, ppc_en_o, ppc_high_o;
  logic if_clk_en_o, host_mode_o, busy_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_pwrup_seq #(.WAIT_TICKS(WT)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctl_tick_i(ctl_tick_i),
    .div_sel_i(div_sel_i), .ref_sel_i(ref_sel_i), .mult_i(mult_i), .ppc_high_i(ppc_high_i),
    .phy_rst_o(phy_rst_o), .hc_rst_o(hc_rst_o), .ctl_rst_o(ctl_rst_o),
    .div_rst_o(div_rst_o), .div_sel_o(div_sel_o), .hclk_en_o(hclk_en_o),
    .ref_sel_o(ref_sel_o), .mult_o(mult_o), .ssc_en_o(ssc_en_o),
    .ss_ref_en_o(ss_ref_en_o), .hs_pwr_o(hs_pwr_o), .ss_pwr_o(ss_pwr_o),
    .ppc_en_o(ppc_en_o), .ppc_high_o(ppc_high_o), .if_clk_en_o(if_clk_en_o),
    .host_mode_o(host_mode_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int idle_vec();
    return {phy_rst_o, hc_rst_o, ctl_rst_o, div_rst_o, hclk_en_o, ssc_en_o, ss_ref_en_o,
            hs_pwr_o, ss_pwr_o, ppc_en_o, ppc_high_o, if_clk_en_o, host_mode_o,
            busy_o, done_o, (div_sel_o != 0), (mult_o != 0), (ref_sel_o != 0)};
  endfunction
  localparam int IDLE_EXP = 18'b111_000000000000_000;

  // One full run; per = tick period in clocks (1..3), poke = start and cfg change mid-run
  task automatic run_seq(int per, logic [2:0] dv, logic [1:0] rs, logic [6:0] ml,
                         logic ph, bit poke);
    int seg, ta, tb, tc, cyc;
    bit seen_drst, seen_hclk, seen_drel, seen_pwr, seen_ctl, seen_ppc, seen_hc;
    bit seen_if, seen_host;
    seg = 0; ta = 0; tb = 0; tc = 0;
    seen_drst = 0; seen_hclk = 0; seen_drel = 0; seen_pwr = 0; seen_ctl = 0;
    seen_ppc = 0; seen_hc = 0; seen_if = 0; seen_host = 0;
    div_sel_i = dv; ref_sel_i = rs; mult_i = ml; ppc_high_i = ph;
    ctl_tick_i = 1'b0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R2 resets asserted on start", {phy_rst_o, hc_rst_o, ctl_rst_o}, 7);
    chk("R2 busy after start", {busy_o, done_o, host_mode_o, if_clk_en_o}, 4'b1000);
    for (cyc = 0; cyc < 3000; cyc++) begin
      if (div_rst_o && !seen_drst) begin
        seen_drst = 1;
        chk("R3 div reset before clock enable", hclk_en_o, 0);
      end
      if (hclk_en_o && !seen_hclk) begin
        seen_hclk = 1;
        chk("R3 div reset held at clock enable", {seen_drst, div_rst_o}, 3);
        chk("R3 divider code applied", div_sel_o, dv);
      end
      if (seen_drst && !div_rst_o && !seen_drel) begin
        seen_drel = 1;
        chk("R3 div released after config", hclk_en_o, 1);
      end
      if (hs_pwr_o && !seen_pwr) begin
        seen_pwr = 1; seg = 1;
        chk("R4 power before any release", {phy_rst_o, hc_rst_o, ctl_rst_o}, 7);
        chk("R4 power enables", {ssc_en_o, ss_ref_en_o, ss_pwr_o}, 7);
        chk("R4 ref select applied", ref_sel_o, rs);
        chk("R4 multiplier applied", mult_o, ml);
      end
      if (seen_pwr && !ctl_rst_o && !seen_ctl) begin
        seen_ctl = 1; seg = 2;
        if (per == 1) chk("R5 ticks before ctl release", ta, WT + 1);
        else chk_rng("R5 ticks before ctl release", ta, WT, WT + 1);
      end
      if (ppc_en_o && !seen_ppc) begin
        seen_ppc = 1; seg = 0;
        chk_rng("R5 ticks after ctl release", tb, WT, WT + 1);
        chk("R6 ppc before hc release", {hc_rst_o, ppc_high_o}, {1'b1, ph});
      end
      if (seen_ppc && !hc_rst_o && !seen_hc) begin
        seen_hc = 1; seg = 3;
        chk("R5 ctl released before hc", ctl_rst_o, 0);
      end
      if (if_clk_en_o && !seen_if) begin
        seen_if = 1; seg = 0;
        chk_rng("R6 ticks after hc release", tc, WT, WT + 1);
        chk("R8 host mode after if clock", host_mode_o, 0);
      end
      if (host_mode_o && !seen_host) begin
        seen_host = 1;
        chk("R7 phy still in reset at host select", {phy_rst_o, done_o}, 2);
      end
      if (done_o) begin
        chk("R7 phy released last with done", {phy_rst_o, busy_o, seen_host}, 1);
        chk("R9 latched divider kept", div_sel_o, dv);
        break;
      end
      if (poke && cyc == 8) begin
        start_i = 1'b1; div_sel_i = ~dv; mult_i = ~ml;
      end else begin
        start_i = 1'b0;
      end
      if (poke && cyc == 9)
        chk("R9 start while busy ignored", {busy_o, phy_rst_o, seen_pwr}, 7);
      ctl_tick_i = (cyc % per) == 0;
      if (seg == 1) ta += int'(ctl_tick_i);
      if (seg == 2) tb += int'(ctl_tick_i);
      if (seg == 3) tc += int'(ctl_tick_i);
      @(negedge clk);
    end
    start_i = 1'b0; ctl_tick_i = 1'b0;
    chk("R7 run reached done", done_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    #1 chk("R1 idle during reset", idle_vec(), IDLE_EXP);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", idle_vec(), IDLE_EXP);

    // sweep tick period and polarity / configs
    for (int p = 1; p <= 3; p++) begin
      for (int h = 0; h < 2; h++) begin
        run_seq(p, 3'(p + 2 * h), 2'(p), 7'(25 * p + h), h[0], 1'b0);
        repeat (5) @(negedge clk);
        chk("R10 done held", {done_o, phy_rst_o, host_mode_o}, 5);
      end
    end

    // start and config change while busy
    run_seq(2, 3'd5, 2'd3, 7'h28, 1'b1, 1'b1);

    // R12: no ticks, sequence stalls in first wait
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (60) @(negedge clk);
    chk("R12 stalled without ticks", {busy_o, ctl_rst_o, hs_pwr_o}, 7);
    // R11: asynchronous reset mid-run
    rst_n = 1'b0;
    #1 chk("R11 async reset to idle", idle_vec(), IDLE_EXP);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after release", idle_vec(), IDLE_EXP);

    // rerun after done re-asserts everything (R10, R2)
    run_seq(1, 3'd1, 2'd0, 7'h19, 1'b0, 1'b0);
    chk("R10 done before rerun", done_o, 1);
    run_seq(3, 3'd7, 2'd2, 7'h32, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule